// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block is the bus-master data mover for one disk channel. Software places a chain of 16-byte descriptors in memory, programs a pointer to the first one and an address for a 128-byte completion area, and sets the start bit. The engine then fetches each descriptor and moves its segment word by word. In one direction it takes words from the device-side stream and writes them to memory. In the other it reads them from memory and hands them to the device side.

When the segment of the descriptor flagged as the last one has been moved, the engine fills the completion area with all-ones words. It then raises the transfer interrupt. Host code polling that area can therefore tell that every data write has landed before the interrupt. A stop request aborts a transfer; its bit reads back as set until the engine is idle. A memory error response halts the engine and flags an error instead.

The memory port is a request/acknowledge port with one 32-bit word per transaction. Words are big-endian: the byte at the lowest address sits in bits 31:24. A request may be withdrawn only by a stop. Registers are selected by word index; the byte offset is the index times four.

Top module: `sgdma_top`

## Requirements
- R1: After reset the control/status word, both byte counters, the interrupt status and the interrupt enable all read 0, and `irqOut` is low.
- R2: A descriptor at byte address D is read as two memory words: D+4 gives the 32-bit buffer address, and D+12 gives the length in bits 15:0 and the last-descriptor flag in bit 31. Bits 30:16 of that word are ignored, the words at D and D+8 are never fetched, and the next descriptor sits at D+16.
- R3: A length field of 0 moves 65536 bytes (16384 words); otherwise the segment moves length/4 words at consecutive addresses.
- R4: With direction bit 2 of the control word set to 1, each word accepted on the device input stream is written, in order, to the next segment address.
- R5: With direction bit 2 at 0, each segment word is read from memory and presented, in order, on the device output stream.
- R6: After the last data word of the flagged descriptor, the engine writes 32 words of all-ones at end-marker address E, E+4, ..., E+124. It then sets interrupt status bit 0, and control bit 3 (active) falls.
- R7: Index 5 counts device-side bytes and index 6 counts memory-side data bytes. Each adds 4 per word moved on its side, and an accepted start clears both.
- R8: A write to the control word at index 7 while active is ignored: it neither restarts the engine nor changes the direction bit.
- R9: Writing 1 to control bit 1 requests a stop. The engine halts without writing the end marker or raising an interrupt, and bit 1 clears by itself the cycle after the engine is idle.
- R10: A memory response with the error flag halts the engine. It sets control bit 4 and interrupt status bit 1, and no end marker is written; the next accepted start clears bit 4.
- R11: Interrupt status at index 9 clears on writing 1 to a bit and is unchanged by writing 0. Index 10 is a two-bit enable mask, and `irqOut` is high when any status bit is both set and enabled.
- R12: Index 0 is a free read/write timing word. Index 1 is the descriptor list pointer and index 8 the end-marker address, both read/write. Index 3 reads the current data address, which ends one word past the last word moved. Indexes 2 and 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 4 | Register word index |
| regWData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regIdx |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request completes this cycle |
| memErr | input | 1 | Error response, valid with memAck |
| devInValid | input | 1 | Device word available |
| devInReady | output | 1 | Engine accepts a device word |
| devInData | input | 32 | Device word to memory |
| devOutValid | output | 1 | Word for the device available |
| devOutReady | input | 1 | Device accepts the word |
| devOutData | output | 32 | Word from memory to device |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench predicts every memory transaction, including the descriptor fetches, and every device word, then compares them as they happen. A design that fetched the zero words, trusted bits 30:16, or stepped descriptors by the wrong stride would issue a wrong address at once. A design that read a zero length as empty, or as a short count, would stop after the first word or miss the 16384th. Error, stop and start-while-active are each exercised: a design that wrote the marker after an error, left the stop bit set, or let a second start change the direction shows it in the status word or the completion area. After an error the bench also checks that the device and memory byte counters differ, which catches a design that keeps one shared count.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam logic [3:0] IDX_TIMING = 4'd0;
  localparam logic [3:0] IDX_DPTR   = 4'd1;
  localparam logic [3:0] IDX_DPTR_H = 4'd2;
  localparam logic [3:0] IDX_CUR    = 4'd3;
  localparam logic [3:0] IDX_CUR_H  = 4'd4;
  localparam logic [3:0] IDX_DEVCNT = 4'd5;
  localparam logic [3:0] IDX_MEMCNT = 4'd6;
  localparam logic [3:0] IDX_CTRL   = 4'd7;
  localparam logic [3:0] IDX_ENDA   = 4'd8;
  localparam logic [3:0] IDX_ISTAT  = 4'd9;
  localparam logic [3:0] IDX_IEN    = 4'd10;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_A, S_FETCH_L, S_DEV_IN, S_MEM_WR, S_MEM_RD, S_DEV_OUT, S_MARK
  } state_t;

  typedef enum logic [1:0] { MS_DESC_A, MS_DESC_L, MS_DATA, MS_MARK } memSel_t;

  typedef struct packed {
    logic loadPtr;
    logic takeAddr;
    logic takeLen;
    logic nextDesc;
    logic capDev;
    logic capMem;
    logic advance;
    logic incDev;
    logic incMem;
    logic markInit;
    logic markStep;
  } strobe_t;

endpackage

// File: rtl/sgdma_datapath.sv
module sgdma_datapath
  import sgdma_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regIdx,
  input  logic [31:0] regWData,
  input  strobe_t     stb,
  input  memSel_t     memSel,
  input  logic [31:0] memRData,
  input  logic [31:0] devInData,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  output logic [31:0] devOutData,
  output logic        segEmpty,
  output logic        rawEol,
  output logic        eolFlag,
  output logic        lastWord,
  output logic        markLast,
  output logic [31:0] timingReg,
  output logic [31:0] descPtrReg,
  output logic [31:0] curAddr,
  output logic [31:0] endAddr,
  output logic [31:0] devCount,
  output logic [31:0] memCount
);
  localparam int MARK_WORDS = MARK_BYTES / 4;
  localparam int MARK_IDX_W = $clog2(MARK_WORDS);
  localparam int WCNT_W     = LEN_W - 1;

  logic [31:0]           descCur;
  logic [31:0]           dataBuf;
  logic [WCNT_W-1:0]     wordsLeft;
  logic [WCNT_W-1:0]     segWords;
  logic [LEN_W-1:0]      lenField;
  logic [MARK_IDX_W-1:0] markIdx;

  assign lenField = memRData[LEN_W-1:0];
  // zero length field encodes the full 64 KiB segment
  assign segWords = (lenField == '0) ? (WCNT_W'(1) << (LEN_W - 2))
                                     : WCNT_W'(lenField >> 2);
  assign segEmpty = (segWords == '0);
  assign rawEol   = memRData[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timingReg  <= '0;
      descPtrReg <= '0;
      endAddr    <= '0;
      descCur    <= '0;
      curAddr    <= '0;
      dataBuf    <= '0;
      wordsLeft  <= '0;
      eolFlag    <= 1'b0;
      devCount   <= '0;
      memCount   <= '0;
      markIdx    <= '0;
    end else begin
      if (regWe) begin
        case (regIdx)
          IDX_TIMING: timingReg  <= regWData;
          IDX_DPTR:   descPtrReg <= regWData;
          IDX_ENDA:   endAddr    <= regWData;
          default: ;
        endcase
      end
      if (stb.loadPtr) begin
        descCur  <= descPtrReg;
        devCount <= '0;
        memCount <= '0;
      end
      if (stb.takeAddr) curAddr <= memRData;
      if (stb.takeLen) begin
        wordsLeft <= segWords;
        eolFlag   <= rawEol;
      end
      if (stb.nextDesc) descCur <= descCur + 32'd16;
      if (stb.capDev) dataBuf <= devInData;
      if (stb.capMem) dataBuf <= memRData;
      if (stb.advance) begin
        curAddr   <= curAddr + 32'd4;
        wordsLeft <= wordsLeft - 1'b1;
      end
      if (stb.incDev) devCount <= devCount + 32'd4;
      if (stb.incMem) memCount <= memCount + 32'd4;
      if (stb.markInit) markIdx <= '0;
      if (stb.markStep) markIdx <= markIdx + 1'b1;
    end
  end

  always_comb begin
    case (memSel)
      MS_DESC_A: memAddr = descCur + 32'd4;
      MS_DESC_L: memAddr = descCur + 32'd12;
      MS_MARK:   memAddr = endAddr + 32'({markIdx, 2'b00});
      default:   memAddr = curAddr;
    endcase
  end

  assign memWData   = (memSel == MS_MARK) ? '1 : dataBuf;
  assign devOutData = dataBuf;
  assign lastWord   = (wordsLeft == WCNT_W'(1));
  assign markLast   = (markIdx == MARK_IDX_W'(MARK_WORDS - 1));

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regIdx,
  input  logic [2:0]  wrBits,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        devInValid,
  input  logic        devOutReady,
  input  logic        segEmpty,
  input  logic        rawEol,
  input  logic        eolFlag,
  input  logic        lastWord,
  input  logic        markLast,
  output strobe_t     stb,
  output memSel_t     memSel,
  output logic        memReq,
  output logic        memWe,
  output logic        devInReady,
  output logic        devOutValid,
  output logic        dirBit,
  output logic        stopReq,
  output logic        active,
  output logic        errFlag,
  output logic [1:0]  irqStat,
  output logic [1:0]  irqEn
);
  state_t state, nextState;
  logic   ctrlWr, startAcc, memDone, memFail, memOk;
  logic   devInHs, devOutHs, doneEv, errEv, segEnd, segEol;
  logic [1:0] clrBits;

  assign ctrlWr   = regWe && (regIdx == IDX_CTRL);
  assign startAcc = ctrlWr && wrBits[0] && !wrBits[1] && (state == S_IDLE);
  assign memDone  = memReq && memAck;
  assign memFail  = memDone && memErr;
  assign memOk    = memDone && !memErr;
  assign devInHs  = devInReady && devInValid;
  assign devOutHs = devOutValid && devOutReady;
  assign active   = (state != S_IDLE);

  always_comb begin
    nextState   = state;
    stb         = '0;
    memSel      = MS_DATA;
    memReq      = 1'b0;
    memWe       = 1'b0;
    devInReady  = 1'b0;
    devOutValid = 1'b0;
    doneEv      = 1'b0;
    errEv       = 1'b0;
    segEnd      = 1'b0;
    segEol      = eolFlag;
    case (state)
      S_IDLE: if (startAcc) begin
        stb.loadPtr = 1'b1;
        nextState   = S_FETCH_A;
      end
      S_FETCH_A: begin
        memReq = 1'b1;
        memSel = MS_DESC_A;
        if (memOk) begin
          stb.takeAddr = 1'b1;
          nextState    = S_FETCH_L;
        end
      end
      S_FETCH_L: begin
        memReq = 1'b1;
        memSel = MS_DESC_L;
        if (memOk) begin
          stb.takeLen = 1'b1;
          if (segEmpty) begin
            segEnd = 1'b1;
            segEol = rawEol;
          end else begin
            nextState = dirBit ? S_DEV_IN : S_MEM_RD;
          end
        end
      end
      S_DEV_IN: begin
        devInReady = 1'b1;
        if (devInValid) begin
          stb.capDev = 1'b1;
          stb.incDev = 1'b1;
          nextState  = S_MEM_WR;
        end
      end
      S_MEM_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memOk) begin
          stb.incMem  = 1'b1;
          stb.advance = 1'b1;
          if (lastWord) segEnd = 1'b1;
          else nextState = S_DEV_IN;
        end
      end
      S_MEM_RD: begin
        memReq = 1'b1;
        if (memOk) begin
          stb.capMem = 1'b1;
          stb.incMem = 1'b1;
          nextState  = S_DEV_OUT;
        end
      end
      S_DEV_OUT: begin
        devOutValid = 1'b1;
        if (devOutReady) begin
          stb.incDev  = 1'b1;
          stb.advance = 1'b1;
          if (lastWord) segEnd = 1'b1;
          else nextState = S_MEM_RD;
        end
      end
      S_MARK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        memSel = MS_MARK;
        if (memOk) begin
          stb.markStep = 1'b1;
          if (markLast) begin
            doneEv    = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
    if (segEnd) begin
      if (segEol) begin
        stb.markInit = 1'b1;
        nextState    = S_MARK;
      end else begin
        stb.nextDesc = 1'b1;
        nextState    = S_FETCH_A;
      end
    end
    if (memFail) begin
      stb       = '0;
      errEv     = 1'b1;
      nextState = S_IDLE;
    end else if (stopReq && active && !memDone && !devInHs && !devOutHs) begin
      stb       = '0;
      nextState = S_IDLE;
    end
  end

  assign clrBits = (regWe && regIdx == IDX_ISTAT) ? wrBits[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      dirBit  <= 1'b0;
      stopReq <= 1'b0;
      errFlag <= 1'b0;
      irqStat <= '0;
      irqEn   <= '0;
    end else begin
      state <= nextState;
      if (ctrlWr && state == S_IDLE) dirBit <= wrBits[2];
      if (ctrlWr && wrBits[1]) stopReq <= 1'b1;
      else if (state == S_IDLE) stopReq <= 1'b0;
      if (errEv) errFlag <= 1'b1;
      else if (startAcc) errFlag <= 1'b0;
      irqStat <= (irqStat & ~clrBits) | {errEv, doneEv};
      if (regWe && regIdx == IDX_IEN) irqEn <= wrBits[1:0];
    end
  end

endmodule

// File: rtl/sgdma_top.sv
module sgdma_top
  import sgdma_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MARK_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regIdx,
  input  logic [31:0] regWData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  input  logic [31:0] memRData,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        devInValid,
  output logic        devInReady,
  input  logic [31:0] devInData,
  output logic        devOutValid,
  input  logic        devOutReady,
  output logic [31:0] devOutData,
  output logic        irqOut
);
  strobe_t     stb;
  memSel_t     memSel;
  logic        segEmpty, rawEol, eolFlag, lastWord, markLast;
  logic        dirBit, stopReq, active, errFlag;
  logic [1:0]  irqStat, irqEn;
  logic [31:0] timingReg, descPtrReg, curAddr, endAddr, devCount, memCount;
  logic [31:0] ctrlWord;

  sgdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .wrBits(regWData[2:0]),
    .memAck(memAck), .memErr(memErr), .devInValid(devInValid), .devOutReady(devOutReady),
    .segEmpty(segEmpty), .rawEol(rawEol), .eolFlag(eolFlag), .lastWord(lastWord),
    .markLast(markLast), .stb(stb), .memSel(memSel), .memReq(memReq), .memWe(memWe),
    .devInReady(devInReady), .devOutValid(devOutValid), .dirBit(dirBit),
    .stopReq(stopReq), .active(active), .errFlag(errFlag), .irqStat(irqStat), .irqEn(irqEn)
  );

  sgdma_datapath #(.LEN_W(LEN_W), .MARK_BYTES(MARK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWData(regWData),
    .stb(stb), .memSel(memSel), .memRData(memRData), .devInData(devInData),
    .memAddr(memAddr), .memWData(memWData), .devOutData(devOutData),
    .segEmpty(segEmpty), .rawEol(rawEol), .eolFlag(eolFlag), .lastWord(lastWord),
    .markLast(markLast), .timingReg(timingReg), .descPtrReg(descPtrReg),
    .curAddr(curAddr), .endAddr(endAddr), .devCount(devCount), .memCount(memCount)
  );

  assign ctrlWord = {27'd0, errFlag, active, dirBit, stopReq, 1'b0};

  always_comb begin
    case (regIdx)
      IDX_TIMING: regRdData = timingReg;
      IDX_DPTR:   regRdData = descPtrReg;
      IDX_CUR:    regRdData = curAddr;
      IDX_DEVCNT: regRdData = devCount;
      IDX_MEMCNT: regRdData = memCount;
      IDX_CTRL:   regRdData = ctrlWord;
      IDX_ENDA:   regRdData = endAddr;
      IDX_ISTAT:  regRdData = {30'd0, irqStat};
      IDX_IEN:    regRdData = {30'd0, irqEn};
      default:    regRdData = '0;
    endcase
  end

  assign irqOut = |(irqStat & irqEn);

endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [3:0]  regIdx,
  input logic [1:0]  wrBits,
  input logic        memReq,
  input logic        memAck,
  input logic        memErr,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWData,
  input logic        stopReq,
  input logic        active,
  input logic        errFlag,
  input logic        dirBit,
  input logic [1:0]  irqStat
);
  // R2, R4: an unanswered request holds its address, kind and data
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !stopReq) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  // R9: stop bit drops the cycle after the engine is idle
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !active && !(regWe && regIdx == 4'd7 && wrBits[1])) |=> !stopReq);

  // R8: control writes while running leave the direction alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (active && regWe && regIdx == 4'd7) |=> $stable(dirBit));

  // R10: error response halts and flags
  a_r10_err_halts: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> (!active && errFlag && irqStat[1]));

  // R11: write-one clears the transfer interrupt
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regIdx == 4'd9 && wrBits[0] && !active) |=> !irqStat[0]);

endmodule

bind sgdma_top sgdma_checker u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .wrBits(regWData[1:0]),
  .memReq(memReq), .memAck(memAck), .memErr(memErr), .memWe(memWe),
  .memAddr(memAddr), .memWData(memWData), .stopReq(stopReq), .active(active),
  .errFlag(errFlag), .dirBit(dirBit), .irqStat(irqStat)
);

// File: tb/tb_sgdma_top.sv
`timescale 1ns/1ps
module tb_sgdma_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWData;
  logic [31:0] memRData = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        devInValid = 1'b0, devInReady;
  logic [31:0] devInData = '0;
  logic        devOutValid, devOutReady = 1'b0;
  logic [31:0] devOutData;
  logic        irqOut;

  sgdma_top dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] memArr [int unsigned];
  logic [31:0] expAddr[$], expData[$], srcQ[$], sinkExp[$];
  bit          expWe[$];
  bit          txnChk = 1'b1, sinkChk = 1'b1;
  logic [31:0] errLo = 0, errHi = 0, wordSeq = 32'hC0DE_0000;

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (memArr.exists(a)) return memArr[a];
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // environment: memory, device source and sink, predicted transactions
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    memAck      = memReq && (cyc % 3 != 1);
    memErr      = memAck && (memAddr >= errLo) && (memAddr < errHi);
    memRData    = memRead(memAddr);
    devInValid  = (srcQ.size() > 0) && (cyc % 4 != 2);
    devInData   = (srcQ.size() > 0) ? srcQ[0] : 32'd0;
    devOutReady = (cyc % 5 != 3);
    #1;
    if (memReq && memAck) begin
      if (txnChk) begin
        if (expAddr.size() == 0) chk("R2 unexpected mem txn addr", memAddr, 32'hDEAD_DEAD);
        else begin
          chk("R2 mem txn address", memAddr, expAddr[0]);
          chk("R4 mem txn kind", 32'(memWe), 32'(expWe[0]));
          if (expWe[0]) chk("R4 mem write data", memWData, expData[0]);
          void'(expAddr.pop_front()); void'(expWe.pop_front()); void'(expData.pop_front());
        end
      end
      if (memWe && !memErr) memArr[memAddr] = memWData;
    end
    if (devInValid && devInReady) void'(srcQ.pop_front());
    if (devOutValid && devOutReady && sinkChk) begin
      if (sinkExp.size() == 0) chk("R5 unexpected device word", devOutData, 32'hDEAD_DEAD);
      else chk("R5 device output word", devOutData, sinkExp.pop_front());
    end
  end

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWData = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] idx, output logic [31:0] val);
    @(negedge clk);
    regIdx = idx;
    #2;
    val = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin regRead(4'd7, v); n++; end while (v[3] && n < 150000);
  endtask

  task automatic putDesc(input logic [31:0] d, input logic [31:0] b,
                         input logic [15:0] len, input bit eol, input logic [14:0] junk);
    memArr[d] = 32'd0; memArr[d + 4] = b; memArr[d + 8] = 32'd0;
    memArr[d + 12] = {eol, junk, len};
  endtask

  task automatic pushTxn(input logic [31:0] a, input bit we, input logic [31:0] dat);
    expAddr.push_back(a); expWe.push_back(we); expData.push_back(dat);
  endtask

  task automatic addSeg(input logic [31:0] d, input logic [31:0] b, input int words, input bit toMem);
    pushTxn(d + 4, 1'b0, 32'd0);
    pushTxn(d + 12, 1'b0, 32'd0);
    for (int i = 0; i < words; i++) begin
      logic [31:0] a;
      a = b + 32'(4 * i);
      if (toMem) begin
        srcQ.push_back(wordSeq);
        pushTxn(a, 1'b1, wordSeq);
        wordSeq++;
      end else begin
        pushTxn(a, 1'b0, 32'd0);
        sinkExp.push_back(memRead(a));
      end
    end
  endtask

  task automatic addMark(input logic [31:0] e);
    for (int i = 0; i < 32; i++) pushTxn(e + 32'(4 * i), 1'b1, 32'hFFFF_FFFF);
  endtask

  task automatic checkMark(input string tag, input logic [31:0] e, input bit expectOnes);
    int ones = 0;
    for (int i = 0; i < 32; i++) if (memRead(e + 32'(4 * i)) == 32'hFFFF_FFFF) ones++;
    chk(tag, 32'(ones), expectOnes ? 32'd32 : 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'd7, v);  chk("R1 control word", v, 0);
    regRead(4'd5, v);  chk("R1 device count", v, 0);
    regRead(4'd6, v);  chk("R1 memory count", v, 0);
    regRead(4'd9, v);  chk("R1 irq status", v, 0);
    regRead(4'd10, v); chk("R1 irq enable", v, 0);
    chk("R1 irqOut", 32'(irqOut), 0);

    // R12 register map
    regWrite(4'd0, 32'h0000_1234);
    regRead(4'd0, v);  chk("R12 timing word", v, 32'h0000_1234);
    regWrite(4'd1, 32'h0001_0000);
    regRead(4'd1, v);  chk("R12 list pointer", v, 32'h0001_0000);
    regWrite(4'd8, 32'h0004_0000);
    regRead(4'd8, v);  chk("R12 end address", v, 32'h0004_0000);
    regRead(4'd2, v);  chk("R12 pointer high", v, 0);
    regRead(4'd4, v);  chk("R12 address high", v, 0);

    // R4 R6 R7: device to memory over two descriptors
    putDesc(32'h0001_0000, 32'h0002_0000, 16'd8, 1'b0, 15'd0);
    putDesc(32'h0001_0010, 32'h0003_0100, 16'd12, 1'b1, 15'd0);
    addSeg(32'h0001_0000, 32'h0002_0000, 2, 1'b1);
    addSeg(32'h0001_0010, 32'h0003_0100, 3, 1'b1);
    addMark(32'h0004_0000);
    regWrite(4'd7, 32'h5);
    waitIdle();
    chk("R2 all predicted txns seen", 32'(expAddr.size()), 0);
    chk("R4 source drained", 32'(srcQ.size()), 0);
    checkMark("R6 end marker ones", 32'h0004_0000, 1'b1);
    regRead(4'd9, v);  chk("R6 transfer irq status", v, 32'd1);
    regRead(4'd7, v);  chk("R6 control after done", v, 32'h4);
    regRead(4'd5, v);  chk("R7 device count", v, 32'd20);
    regRead(4'd6, v);  chk("R7 memory count", v, 32'd20);
    regRead(4'd3, v);  chk("R12 current address", v, 32'h0003_010C);

    // R11 interrupt status and enable
    chk("R11 irqOut masked", 32'(irqOut), 0);
    regWrite(4'd10, 32'h1);
    @(negedge clk); #2; chk("R11 irqOut enabled", 32'(irqOut), 1);
    regWrite(4'd9, 32'h0);
    regRead(4'd9, v);  chk("R11 write 0 keeps status", v, 32'd1);
    regWrite(4'd9, 32'h1);
    regRead(4'd9, v);  chk("R11 write 1 clears status", v, 32'd0);
    chk("R11 irqOut after clear", 32'(irqOut), 0);

    // R5 R2 R8: memory to device, junk in bits 30:16, start while active
    putDesc(32'h0001_0100, 32'h0005_0000, 16'd16, 1'b1, 15'h7FFF);
    regWrite(4'd1, 32'h0001_0100);
    regWrite(4'd8, 32'h0004_1000);
    addSeg(32'h0001_0100, 32'h0005_0000, 4, 1'b0);
    addMark(32'h0004_1000);
    regWrite(4'd7, 32'h1);
    regWrite(4'd7, 32'h5);
    regRead(4'd7, v);  chk("R8 running, direction unchanged", v & 32'h1C, 32'h8);
    waitIdle();
    chk("R8 no restart txns", 32'(expAddr.size()), 0);
    chk("R5 all words delivered", 32'(sinkExp.size()), 0);
    regRead(4'd6, v);  chk("R7 memory count m2d", v, 32'd16);

    // R3 zero length means 65536 bytes
    putDesc(32'h0001_0200, 32'h0010_0000, 16'd0, 1'b1, 15'd0);
    regWrite(4'd1, 32'h0001_0200);
    regWrite(4'd8, 32'h0004_2000);
    addSeg(32'h0001_0200, 32'h0010_0000, 16384, 1'b0);
    addMark(32'h0004_2000);
    regWrite(4'd7, 32'h1);
    waitIdle();
    chk("R3 full segment words", 32'(sinkExp.size()), 0);
    regRead(4'd5, v);  chk("R3 device bytes", v, 32'd65536);
    checkMark("R6 marker after long run", 32'h0004_2000, 1'b1);

    // R9 stop handshake
    txnChk = 1'b0; sinkChk = 1'b0;
    expAddr.delete(); expWe.delete(); expData.delete(); sinkExp.delete();
    regWrite(4'd9, 32'h3);
    putDesc(32'h0001_0300, 32'h0020_0000, 16'd0, 1'b1, 15'd0);
    regWrite(4'd1, 32'h0001_0300);
    regWrite(4'd8, 32'h0004_3000);
    regWrite(4'd7, 32'h1);
    repeat (40) @(negedge clk);
    regWrite(4'd7, 32'h2);
    regRead(4'd7, v);  chk("R9 stop bit held", v & 32'h2, 32'h2);
    begin
      int n = 0;
      do begin regRead(4'd7, v); n++; end while (v[1] && n < 20);
    end
    chk("R9 halted, stop self-cleared", v, 32'h0);
    regRead(4'd9, v);  chk("R9 no interrupt on stop", v, 32'd0);
    checkMark("R9 no marker on stop", 32'h0004_3000, 1'b0);

    // R10 memory error
    errLo = 32'h0080_0000; errHi = 32'h0080_0040;
    putDesc(32'h0001_0400, 32'h0080_0000, 16'd8, 1'b1, 15'd0);
    srcQ.push_back(32'h1111_0001); srcQ.push_back(32'h1111_0002);
    regWrite(4'd1, 32'h0001_0400);
    regWrite(4'd8, 32'h0004_4000);
    regWrite(4'd7, 32'h5);
    waitIdle();
    regRead(4'd7, v);  chk("R10 error bit set", v, 32'h14);
    regRead(4'd9, v);  chk("R10 error irq", v, 32'd2);
    checkMark("R10 no marker on error", 32'h0004_4000, 1'b0);
    regRead(4'd5, v);  chk("R7 device count after error", v, 32'd4);
    regRead(4'd6, v);  chk("R7 memory count after error", v, 32'd0);
    srcQ.delete(); errLo = 0; errHi = 0;

    // R10 next start clears error
    txnChk = 1'b1; sinkChk = 1'b1;
    putDesc(32'h0001_0500, 32'h0030_0000, 16'd4, 1'b1, 15'd0);
    regWrite(4'd1, 32'h0001_0500);
    regWrite(4'd8, 32'h0004_5000);
    addSeg(32'h0001_0500, 32'h0030_0000, 1, 1'b1);
    addMark(32'h0004_5000);
    regWrite(4'd7, 32'h5);
    waitIdle();
    regRead(4'd7, v);  chk("R10 error cleared by start", v, 32'h4);
    chk("R4 recovery txns", 32'(expAddr.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule